// File: doc/BRIEF.md
# SPI Command Frame Monitor

This block sits passively on an SPI link (mode 0) between a host and a peripheral that is driven by one-byte commands and whose control registers are split into four banks. It brings chip-select, serial clock and both data lines into the system clock domain, assembles the bits into bytes and gathers every byte exchanged while chip-select is low into one frame. It never drives the bus.

When chip-select rises, the monitor decodes the opcode from the first byte and checks the frame's length and header against the rule for that opcode. It reports one record per frame: opcode, register address, the bank in force, whether that bank is known, the byte count, the first data byte and a set of error and warning flags. It keeps its own copy of the two bank-select bits by watching whole-register writes and bit set/clear commands aimed at the bank control register. A register access made before both bits are known is flagged.

Top module: `spi_cmd_monitor`

## Requirements
- R1: When chip-select (active low) rises after a frame of one or more whole bytes, `frame_valid` is high for exactly one clock cycle. A chip-select pulse with no whole byte produces no pulse.
- R2: Bits are taken on rising SCLK edges while chip-select is low, most significant bit first. `frame_op` is bits 7:5 of the first MOSI byte and `frame_addr` is bits 4:0.
- R3: Opcode 3'b110 sets `err_unknown_op` and clears every other error and warning flag. In that case `frame_data` is 0.
- R4: Opcodes 3'b010 (register write), 3'b100 (bit set) and 3'b101 (bit clear) need exactly 2 bytes, and opcode 3'b111 (reset) needs exactly 1 byte. Any other count sets `err_length`.
- R5: Opcode 3'b000 (register read) needs 2 or 3 bytes, otherwise `err_length` is set. `frame_data` is the MISO byte at position 2 in a 2-byte frame and at position 3 in a 3-byte frame (the second byte is a dummy).
- R6: The buffer read frame (opcode 3'b001) must begin with 0x3A and the buffer write frame (opcode 3'b011) with 0x7A, otherwise `err_header` is set. Any length is accepted. `frame_data` is the second MISO byte (read) or the second MOSI byte (write), or 0 if the frame has only the header.
- R7: An error-free register write to address 0x1F loads the bank bits from bits 1:0 of its data byte and marks both bits known. The bank number is bit1*2 + bit0.
- R8: An error-free bit set to 0x1F sets, and a bit clear to 0x1F clears, each bank bit whose data bit is 1, and marks that bit known. Bank bits whose data bit is 0 keep their value and their known state.
- R9: After reset both bank bits are unknown and read as 0. `frame_bank` and `frame_bank_known` give the state from before the frame. An error-free read, write, set or clear made while either bit is unknown raises `warn_bank_unknown`.
- R10: `frame_len` counts the whole bytes in the frame and saturates at 255.
- R11: If chip-select rises partway through a byte, that partial byte is dropped and does not count.
- R12: After reset `frame_valid` and all flag outputs are 0.
- R13: In every error-free frame other than a reset, `frame_data` carries the data byte selected by the opcode rule: the second MOSI byte for write, set and clear frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_cs_n | input | 1 | Bus chip-select, active low |
| spi_sclk | input | 1 | Bus serial clock |
| spi_mosi | input | 1 | Host-to-peripheral data |
| spi_miso | input | 1 | Peripheral-to-host data |
| frame_valid | output | 1 | One-cycle pulse per completed frame |
| frame_op | output | 3 | Opcode of the frame |
| frame_addr | output | 5 | Register address field |
| frame_bank | output | 2 | Shadow bank before the frame |
| frame_bank_known | output | 1 | Both bank bits known before the frame |
| frame_len | output | 8 | Whole bytes in the frame, saturating |
| frame_data | output | 8 | First data byte chosen by the opcode rule |
| err_unknown_op | output | 1 | Undefined opcode |
| err_length | output | 1 | Byte count breaks the opcode rule |
| err_header | output | 1 | Buffer command header is not the exact value |
| warn_bank_unknown | output | 1 | Register access while the bank is unknown |

## Verification
The bench builds the monitor with its default parameters: two synchroniser stages, bank control register at 0x1F and an 8-bit byte counter. The 8-bit counter lets a 256-byte buffer-write frame reach the saturation point, and the short synchroniser lets SCLK run at three system clocks per half period. Random frames that often target 0x1F move the shadow bank through partly known and fully known states, which makes the warning rule and the per-bit set/clear update reachable alongside the length and header rules.

// File: rtl/spi_mon_pkg.sv
package spi_mon_pkg;

  typedef enum logic [2:0] {
    OP_RDREG   = 3'b000,
    OP_RDBUF   = 3'b001,
    OP_WRREG   = 3'b010,
    OP_WRBUF   = 3'b011,
    OP_SETBITS = 3'b100,
    OP_CLRBITS = 3'b101,
    OP_UNDEF   = 3'b110,
    OP_RESET   = 3'b111
  } mon_op_e;

  typedef struct packed {
    logic unknown_op;
    logic bad_len;
    logic bad_hdr;
  } mon_err_t;

  // Length class of a frame, computed once in the top.
  typedef struct packed {
    logic one;
    logic two;
    logic three;
    logic ge_two;
  } len_cls_t;

  function automatic mon_err_t check_frame(input logic [7:0] hdr, input len_cls_t lc,
                                           input logic [7:0] rdbuf_hdr,
                                           input logic [7:0] wrbuf_hdr);
    mon_err_t e;
    e = '0;
    case (mon_op_e'(hdr[7:5]))
      OP_RDREG:                     e.bad_len = !(lc.two || lc.three);
      OP_WRREG, OP_SETBITS, OP_CLRBITS: e.bad_len = !lc.two;
      OP_RESET:                     e.bad_len = !lc.one;
      OP_RDBUF:                     e.bad_hdr = (hdr != rdbuf_hdr);
      OP_WRBUF:                     e.bad_hdr = (hdr != wrbuf_hdr);
      default:                      e.unknown_op = 1'b1;
    endcase
    return e;
  endfunction

  function automatic logic is_reg_access(input logic [2:0] op);
    case (mon_op_e'(op))
      OP_RDREG, OP_WRREG, OP_SETBITS, OP_CLRBITS: return 1'b1;
      default:                                    return 1'b0;
    endcase
  endfunction

  function automatic logic [7:0] pick_data(input logic [2:0] op, input len_cls_t lc,
                                           input logic [7:0] mosi1,
                                           input logic [7:0] miso1,
                                           input logic [7:0] miso2);
    case (mon_op_e'(op))
      OP_RDREG:                         return lc.three ? miso2 : miso1;
      OP_RDBUF:                         return lc.ge_two ? miso1 : 8'h00;
      OP_WRBUF:                         return lc.ge_two ? mosi1 : 8'h00;
      OP_WRREG, OP_SETBITS, OP_CLRBITS: return mosi1;
      default:                          return 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/spi_mon_sync.sv
module spi_mon_sync #(
  parameter int              WIDTH   = 4,
  parameter int              STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_async,
  output logic [WIDTH-1:0] d_sync
);
  logic [WIDTH-1:0] chain [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[s] <= RST_VAL;
      else if (s == 0) chain[s] <= d_async;
      else chain[s] <= chain[(s == 0) ? 0 : s-1];
    end
  end

  assign d_sync = chain[STAGES-1];
endmodule

// File: rtl/spi_mon_deser.sv
module spi_mon_deser #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n_s,
  input  logic              sclk_s,
  input  logic              mosi_s,
  input  logic              miso_s,
  output logic              cs_active,
  output logic              frame_start,
  output logic              frame_end,
  output logic              byte_done,
  output logic [BYTE_W-1:0] mosi_byte,
  output logic [BYTE_W-1:0] miso_byte
);
  localparam int BIT_CW = $clog2(BYTE_W);

  logic              csn_q, sclk_q, sclk_rise, last_bit;
  logic [BIT_CW-1:0] bit_cnt;
  logic [BYTE_W-2:0] sh_mosi, sh_miso;

  assign cs_active   = ~cs_n_s;
  assign frame_start = csn_q & ~cs_n_s;
  assign frame_end   = ~csn_q & cs_n_s;
  assign sclk_rise   = cs_active & sclk_s & ~sclk_q;
  assign last_bit    = (bit_cnt == BIT_CW'(BYTE_W-1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      csn_q     <= 1'b1;
      sclk_q    <= 1'b0;
      bit_cnt   <= '0;
      sh_mosi   <= '0;
      sh_miso   <= '0;
      byte_done <= 1'b0;
      mosi_byte <= '0;
      miso_byte <= '0;
    end else begin
      csn_q     <= cs_n_s;
      sclk_q    <= sclk_s;
      byte_done <= 1'b0;
      if (frame_start || frame_end) begin
        bit_cnt <= '0;  // a partial byte at the end is dropped here
      end else if (sclk_rise) begin
        sh_mosi <= {sh_mosi[BYTE_W-3:0], mosi_s};
        sh_miso <= {sh_miso[BYTE_W-3:0], miso_s};
        if (last_bit) begin
          bit_cnt   <= '0;
          byte_done <= 1'b1;
          mosi_byte <= {sh_mosi, mosi_s};
          miso_byte <= {sh_miso, miso_s};
        end else begin
          bit_cnt <= bit_cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/spi_mon_bank.sv
module spi_mon_bank
  import spi_mon_pkg::*;
#(
  parameter logic [4:0] BANK_ADDR = 5'h1F
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       upd,
  input  logic [2:0] op,
  input  logic [4:0] addr,
  input  logic [1:0] data,
  output logic [1:0] bank_val,
  output logic [1:0] bank_known
);
  logic hit;
  assign hit = upd && (addr == BANK_ADDR);

  for (genvar i = 0; i < 2; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        bank_val[i]   <= 1'b0;
        bank_known[i] <= 1'b0;
      end else if (hit) begin
        case (mon_op_e'(op))
          OP_WRREG: begin
            bank_val[i]   <= data[i];
            bank_known[i] <= 1'b1;
          end
          OP_SETBITS: if (data[i]) begin
            bank_val[i]   <= 1'b1;
            bank_known[i] <= 1'b1;
          end
          OP_CLRBITS: if (data[i]) begin
            bank_val[i]   <= 1'b0;
            bank_known[i] <= 1'b1;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/spi_cmd_monitor.sv
module spi_cmd_monitor
  import spi_mon_pkg::*;
#(
  parameter int         SYNC_STAGES = 2,
  parameter int         LEN_W       = 8,
  parameter logic [4:0] BANK_ADDR   = 5'h1F,
  parameter logic [7:0] RDBUF_HDR   = 8'h3A,
  parameter logic [7:0] WRBUF_HDR   = 8'h7A
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             spi_cs_n,
  input  logic             spi_sclk,
  input  logic             spi_mosi,
  input  logic             spi_miso,
  output logic             frame_valid,
  output logic [2:0]       frame_op,
  output logic [4:0]       frame_addr,
  output logic [1:0]       frame_bank,
  output logic             frame_bank_known,
  output logic [LEN_W-1:0] frame_len,
  output logic [7:0]       frame_data,
  output logic             err_unknown_op,
  output logic             err_length,
  output logic             err_header,
  output logic             warn_bank_unknown
);
  localparam logic [LEN_W-1:0] LEN_MAX = '1;

  logic [3:0] bus_s;
  logic       cs_active, frame_start, frame_end, byte_done;
  logic [7:0] mosi_byte, miso_byte;
  logic [LEN_W-1:0] len_q;
  logic [7:0] hdr_q, mosi1_q, miso1_q, miso2_q;
  logic [1:0] bank_val, known_bits;

  spi_mon_sync #(.WIDTH(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b1000)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d_async({spi_cs_n, spi_sclk, spi_mosi, spi_miso}),
    .d_sync(bus_s)
  );

  spi_mon_deser #(.BYTE_W(8)) u_deser (
    .clk(clk), .rst_n(rst_n),
    .cs_n_s(bus_s[3]), .sclk_s(bus_s[2]), .mosi_s(bus_s[1]), .miso_s(bus_s[0]),
    .cs_active(cs_active), .frame_start(frame_start), .frame_end(frame_end),
    .byte_done(byte_done), .mosi_byte(mosi_byte), .miso_byte(miso_byte)
  );

  // Frame accumulation
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_q   <= '0;
      hdr_q   <= '0;
      mosi1_q <= '0;
      miso1_q <= '0;
      miso2_q <= '0;
    end else if (frame_start) begin
      len_q <= '0;
    end else if (byte_done) begin
      if (len_q == LEN_W'(0)) hdr_q <= mosi_byte;
      if (len_q == LEN_W'(1)) begin
        mosi1_q <= mosi_byte;
        miso1_q <= miso_byte;
      end
      if (len_q == LEN_W'(2)) miso2_q <= miso_byte;
      if (len_q != LEN_MAX) len_q <= len_q + 1'b1;
    end
  end

  // Classification, named for the checker
  len_cls_t   lcls;
  mon_err_t   errs;
  logic       frame_done, frame_clean, bank_upd, bank_load_full, reg_access;
  logic [7:0] data_sel;

  assign lcls.one    = (len_q == LEN_W'(1));
  assign lcls.two    = (len_q == LEN_W'(2));
  assign lcls.three  = (len_q == LEN_W'(3));
  assign lcls.ge_two = (len_q >= LEN_W'(2));

  assign errs           = check_frame(hdr_q, lcls, RDBUF_HDR, WRBUF_HDR);
  assign frame_done     = frame_end && (len_q != '0);
  assign frame_clean    = (errs == '0);
  assign bank_upd       = frame_done && frame_clean;
  assign bank_load_full = bank_upd && (hdr_q[7:5] == OP_WRREG) && (hdr_q[4:0] == BANK_ADDR);
  assign reg_access     = is_reg_access(hdr_q[7:5]);
  assign data_sel       = frame_clean ? pick_data(hdr_q[7:5], lcls, mosi1_q, miso1_q, miso2_q)
                                      : 8'h00;

  spi_mon_bank #(.BANK_ADDR(BANK_ADDR)) u_bank (
    .clk(clk), .rst_n(rst_n), .upd(bank_upd),
    .op(hdr_q[7:5]), .addr(hdr_q[4:0]), .data(mosi1_q[1:0]),
    .bank_val(bank_val), .bank_known(known_bits)
  );

  // Frame report
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_valid       <= 1'b0;
      frame_op          <= '0;
      frame_addr        <= '0;
      frame_bank        <= '0;
      frame_bank_known  <= 1'b0;
      frame_len         <= '0;
      frame_data        <= '0;
      err_unknown_op    <= 1'b0;
      err_length        <= 1'b0;
      err_header        <= 1'b0;
      warn_bank_unknown <= 1'b0;
    end else begin
      frame_valid <= frame_done;
      if (frame_done) begin
        frame_op          <= hdr_q[7:5];
        frame_addr        <= hdr_q[4:0];
        frame_bank        <= bank_val;
        frame_bank_known  <= &known_bits;
        frame_len         <= len_q;
        frame_data        <= data_sel;
        err_unknown_op    <= errs.unknown_op;
        err_length        <= errs.bad_len;
        err_header        <= errs.bad_hdr;
        warn_bank_unknown <= frame_clean && reg_access && !(&known_bits);
      end
    end
  end
endmodule

// File: rtl/spi_cmd_monitor_chk.sv
module spi_cmd_monitor_chk #(
  parameter int LEN_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             frame_valid,
  input logic [2:0]       frame_op,
  input logic             frame_bank_known,
  input logic [LEN_W-1:0] frame_len,
  input logic             err_unknown_op,
  input logic             err_length,
  input logic             err_header,
  input logic             warn_bank_unknown,
  input logic             cs_active,
  input logic             byte_done,
  input logic             bank_load_full,
  input logic [1:0]       known_bits
);
  assert_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n)
    frame_valid |=> !frame_valid);

  assert_nonempty_R1: assert property (@(posedge clk) disable iff (!rst_n)
    frame_valid |-> (frame_len != '0));

  assert_byte_in_frame_R2: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done |-> $past(cs_active));

  assert_undef_alone_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_valid && frame_op == 3'b110) |-> (err_unknown_op && !err_length && !err_header && !warn_bank_unknown));

  assert_flags_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_n)
    frame_valid |-> $countones({err_unknown_op, err_length, err_header}) <= 1);

  assert_load_known_R7: assert property (@(posedge clk) disable iff (!rst_n)
    bank_load_full |=> (known_bits == 2'b11));

  assert_known_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (known_bits == 2'b11) |=> (known_bits == 2'b11));

  assert_warn_unknown_R9: assert property (@(posedge clk) disable iff (!rst_n)
    warn_bank_unknown |-> !frame_bank_known);
endmodule

bind spi_cmd_monitor spi_cmd_monitor_chk #(.LEN_W(LEN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .frame_valid(frame_valid), .frame_op(frame_op),
  .frame_bank_known(frame_bank_known), .frame_len(frame_len),
  .err_unknown_op(err_unknown_op), .err_length(err_length), .err_header(err_header),
  .warn_bank_unknown(warn_bank_unknown), .cs_active(cs_active), .byte_done(byte_done),
  .bank_load_full(bank_load_full), .known_bits(known_bits)
);

// File: tb/tb_spi_cmd_monitor.sv
`timescale 1ns/1ps
module tb_spi_cmd_monitor;
  localparam int HALF = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic spi_cs_n = 1'b1, spi_sclk = 1'b0, spi_mosi = 1'b0, spi_miso = 1'b0;
  logic frame_valid, frame_bank_known, err_unknown_op, err_length, err_header, warn_bank_unknown;
  logic [2:0] frame_op;
  logic [4:0] frame_addr;
  logic [1:0] frame_bank;
  logic [7:0] frame_len, frame_data;

  spi_cmd_monitor dut (.*);

  always #2.5 clk = ~clk;

  int n_run = 0, n_fail = 0, pulses = 0;
  bit finished = 0;
  logic [7:0] tm [0:299];
  logic [7:0] ts [0:299];
  logic [1:0] kv = 2'b00, kk = 2'b00;

  always @(negedge clk) if (frame_valid) pulses++;

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string tag, int act, int exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic send(int nb, int extra);
    spi_cs_n = 1'b0;
    tick(4);
    for (int t = 0; t < nb * 8 + extra; t++) begin
      spi_mosi = tm[t / 8][7 - (t % 8)];
      spi_miso = ts[t / 8][7 - (t % 8)];
      tick(HALF);
      spi_sclk = 1'b1;
      tick(HALF);
      spi_sclk = 1'b0;
    end
    tick(HALF);
    spi_cs_n = 1'b1;
    tick(12);
  endtask

  // Bench-side rules
  function automatic int want_len_err(int op, int n);
    if (op == 0) return (n == 2 || n == 3) ? 0 : 1;
    if (op == 2 || op == 4 || op == 5) return (n == 2) ? 0 : 1;
    if (op == 7) return (n == 1) ? 0 : 1;
    return 0;
  endfunction

  function automatic int want_hdr_err(logic [7:0] h);
    if (h[7:5] == 3'd1) return (h != 8'h3A) ? 1 : 0;
    if (h[7:5] == 3'd3) return (h != 8'h7A) ? 1 : 0;
    return 0;
  endfunction

  function automatic int want_data(int op, int n);
    case (op)
      0: return (n == 3) ? int'(ts[2]) : int'(ts[1]);
      1: return (n > 1) ? int'(ts[1]) : 0;
      3: return (n > 1) ? int'(tm[1]) : 0;
      2, 4, 5: return int'(tm[1]);
      default: return 0;
    endcase
  endfunction

  task automatic run_frame(int n, int extra);
    int p0, op, eu, el, eh, bad, regacc;
    op = int'(tm[0][7:5]);
    eu = (op == 6) ? 1 : 0;
    el = want_len_err(op, n);
    eh = want_hdr_err(tm[0]);
    bad = eu | el | eh;
    regacc = (op == 0 || op == 2 || op == 4 || op == 5) ? 1 : 0;
    p0 = pulses;
    send(n, extra);
    chk("R1 pulse count", pulses - p0, 1);
    chk("R2 opcode", int'(frame_op), op);
    chk("R2 address", int'(frame_addr), int'(tm[0][4:0]));
    chk("R10 length", int'(frame_len), (n > 255) ? 255 : n);
    chk("R3 unknown op", int'(err_unknown_op), eu);
    chk("R4 length error", int'(err_length), el);
    chk("R6 header error", int'(err_header), eh);
    chk("R13 data byte", int'(frame_data), bad ? 0 : want_data(op, n));
    chk("R9 bank known", int'(frame_bank_known), (kk == 2'b11) ? 1 : 0);
    chk("R7 bank value", int'(frame_bank), int'(kv));
    chk("R9 warning", int'(warn_bank_unknown), (!bad && regacc && kk != 2'b11) ? 1 : 0);
    if (!bad && tm[0][4:0] == 5'h1F) begin
      if (op == 2) begin kv = tm[1][1:0]; kk = 2'b11; end
      if (op == 4) begin kv = kv | tm[1][1:0]; kk = kk | tm[1][1:0]; end
      if (op == 5) begin kv = kv & ~tm[1][1:0]; kk = kk | tm[1][1:0]; end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog act=0 exp=1");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    int seed, p0, n;
    seed = 32'h5EED_0017;
    void'($urandom(seed));
    tick(5);
    rst_n = 1'b1;
    tick(5);
    // R12 reset state
    chk("R12 valid", int'(frame_valid), 0);
    chk("R12 flags", int'({err_unknown_op, err_length, err_header, warn_bank_unknown}), 0);
    chk("R12 bank known", int'(frame_bank_known), 0);

    // R1 empty frame: no pulse
    p0 = pulses;
    send(0, 0);
    chk("R1 empty frame", pulses - p0, 0);

    // R9 read before bank known
    tm[0] = 8'h05; ts[1] = 8'hC3;
    run_frame(2, 0);
    // R5 three-byte read with dummy
    tm[0] = 8'h1A; ts[1] = 8'h11; ts[2] = 8'h9E;
    run_frame(3, 0);
    // R8 set only bit 0: still partly unknown
    tm[0] = 8'h9F; tm[1] = 8'h01;
    run_frame(2, 0);
    tm[0] = 8'h03; ts[1] = 8'h44;
    run_frame(2, 0);
    // R8 clear bit 1 -> fully known
    tm[0] = 8'hBF; tm[1] = 8'h02;
    run_frame(2, 0);
    // R7 full write, bank 2
    tm[0] = 8'h5F; tm[1] = 8'hFE;
    run_frame(2, 0);
    tm[0] = 8'h00; ts[1] = 8'h77;
    run_frame(2, 0);
    // R11 partial byte dropped
    tm[0] = 8'h44; tm[1] = 8'h5A; tm[2] = 8'hFF;
    run_frame(2, 3);
    // R4 reset with extra byte, undefined opcode, reset alone
    tm[0] = 8'hFF; run_frame(2, 0);
    tm[0] = 8'hC1; run_frame(1, 0);
    tm[0] = 8'hE0; run_frame(1, 0);
    // R6 headers
    tm[0] = 8'h3A; ts[1] = 8'hA5; run_frame(4, 0);
    tm[0] = 8'h3B; run_frame(2, 0);
    tm[0] = 8'h7A; run_frame(1, 0);
    // R10 long buffer write saturates
    tm[0] = 8'h7A;
    for (int i = 1; i < 300; i++) tm[i] = 8'(i * 7);
    run_frame(256, 0);

    // random frames
    for (int f = 0; f < 40; f++) begin
      for (int i = 0; i < 5; i++) begin
        tm[i] = 8'($urandom);
        ts[i] = 8'($urandom);
      end
      case ($urandom % 4)
        0: tm[0] = ($urandom % 2) ? 8'h3A : 8'h7A;
        1: tm[0][4:0] = 5'h1F;
        default: ;
      endcase
      n = 1 + int'($urandom % 4);
      run_frame(n, 0);
    end

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule